// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a processor-side word port and a simple main-memory port. It caches fixed-size lines of memory. Each byte address is cut into three fields: a tag at the top, a line index in the middle and an offset at the bottom. The index picks the single line where that block may live. A read whose index and tag match a valid line is answered in the same cycle. Any other read stalls the processor while the whole line is fetched from memory, one word per beat, and the held request is then answered from the refilled line.

Every write goes to memory. If the written address is present in the cache, the addressed bytes of the line are updated in the same cycle as the memory handshake. A write that misses does not allocate a line. As a result, a line never holds data newer than memory. Because a block has only one possible line, the replacement choice is implied by the address: a miss always evicts whatever occupies the indexed line.

The controller is a four-state machine:
- `ST_IDLE` serves read hits and launches work.
- `ST_FILL` streams one beat per word of the line.
- `ST_WRITE` holds the memory write until it is acknowledged.
- `ST_WDONE` releases the processor for one cycle.

The transitions are:
- IDLE to FILL on a read miss.
- IDLE to WRITE on any write.
- FILL to IDLE on the last acknowledged beat.
- WRITE to WDONE on the memory acknowledge.
- WDONE to IDLE unconditionally.

Top module: `dm_wt_cache`

## Requirements
- R1: With defaults (24-bit address, 256 lines, 4-byte lines of two 16-bit words) the address splits into tag = addr[23:10], index = addr[9:2], word select = addr[1] and byte = addr[0]. Fill beats use memory address {addr[23:2], beat, 1'b0}.
- R2: Reset clears every valid bit, so the first read of any address afterwards misses. Out of reset, with no request, cpu_stall and mem_req are low.
- R3: A read hit drives cpu_stall low and the addressed word on cpu_rdata in the same cycle as cpu_req, with no memory request.
- R4: A read miss holds cpu_stall high and issues exactly two memory reads, word 0 first and then word 1. In the cycle after the last beat, cpu_stall is low and cpu_rdata carries the requested word. Both words of the line then hit.
- R5: Every write issues exactly one memory write with mem_we high, mem_addr = cpu_addr, mem_wdata = cpu_wdata and mem_be = cpu_be. cpu_stall stays high until the cycle after the handshake.
- R6: A write hit updates only the bytes whose cpu_be bit is set (bit i covers data bits 8i+7:8i), and a following read hit returns the merged word.
- R7: A write miss allocates no line and starts no fill; a later read of that address misses.
- R8: mem_req, once raised, stays high with mem_addr and mem_we unchanged until mem_ready. A transfer takes place in a cycle in which both are high.
- R9: Two blocks with the same index and different tags, read alternately, miss on every access.
- R10: Blocks with different indexes are held at the same time: after both are filled, both hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 24 | Byte address |
| cpu_wdata | input | 16 | Write data |
| cpu_be | input | 2 | Byte enables for writes |
| cpu_rdata | output | 16 | Read data, valid when the request is accepted |
| cpu_stall | output | 1 | High while the request cannot complete |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_be | output | 2 | Memory byte enables |
| mem_rdata | input | 16 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory acknowledge |

## Verification
Each result has a fixed point at which it is due:
- A read hit is due in the very cycle the request is raised.
- A read miss completes in the cycle after the last acknowledged fill beat.
- A write completes in the cycle after its memory handshake.

The bench drives the processor port on the falling edge and samples cpu_stall and cpu_rdata a quarter period later, in every cycle until stall drops. It counts the stalled cycles, so a hit must show zero of them. The memory model answers after a latency that varies from zero to two cycles. It logs each transfer when it acknowledges, so the number, order and addresses of the beats are compared against the field split rather than against any exact cycle count.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WRITE,
        ST_WDONE
    } dmc_state_e;
endpackage

// File: rtl/dmc_store.sv
// Tag, valid and data arrays of the cache with one lookup port.
module dmc_store #(
    parameter int LINES  = 256,
    parameter int TAG_W  = 14,
    parameter int DATA_W = 16,
    parameter int WPL    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(LINES)-1:0]   idx,
    input  logic [TAG_W-1:0]           tag,
    input  logic [$clog2(WPL)-1:0]     wsel,
    output logic                       hit,
    output logic [DATA_W-1:0]          rword,
    input  logic                       fill_en,
    input  logic                       fill_last,
    input  logic [$clog2(WPL)-1:0]     fill_beat,
    input  logic [DATA_W-1:0]          fill_word,
    input  logic                       upd_en,
    input  logic [DATA_W/8-1:0]        upd_be,
    input  logic [DATA_W-1:0]          upd_word
);
    localparam int BE_W = DATA_W / 8;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES][WPL];

    assign hit   = valid_q[idx] && (tag_q[idx] == tag);
    assign rword = data_q[idx][wsel];

    // A line is invalid while it is being overwritten, valid once complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= fill_last;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            data_q[idx][fill_beat] <= fill_word;
            if (fill_last) begin
                tag_q[idx] <= tag;
            end
        end else if (upd_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (upd_be[b]) begin
                    data_q[idx][wsel][8*b +: 8] <= upd_word[8*b +: 8];
                end
            end
        end
    end

    // R4: the line written by the last fill beat is valid afterwards
    a_r4_filled_line_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && fill_last) |=> valid_q[$past(idx)]);

endmodule

// File: rtl/dmc_ctrl.sv
// Sequencing of fills and write-through accesses.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int WPL = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic                    hit,
    input  logic                    mem_ready,
    output logic                    cpu_stall,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [$clog2(WPL)-1:0]  beat,
    output logic                    fill_en,
    output logic                    fill_last,
    output logic                    upd_en
);
    localparam int WS_W = $clog2(WPL);
    localparam logic [WS_W-1:0] LAST = WS_W'(WPL - 1);

    dmc_state_e state_q, state_d;
    logic [WS_W-1:0] beat_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL && mem_ready) begin
                beat_q <= (beat_q == LAST) ? '0 : beat_q + 1'b1;
            end else if (state_q == ST_IDLE) begin
                beat_q <= '0;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && cpu_we) begin
                    state_d = ST_WRITE;
                end else if (cpu_req && !hit) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ready && beat_q == LAST) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    state_d = ST_WDONE;
                end
            end
            ST_WDONE: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_stall = cpu_req;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        fill_en   = 1'b0;
        fill_last = 1'b0;
        upd_en    = 1'b0;
        unique case (state_q)
            ST_IDLE:  cpu_stall = cpu_req && (cpu_we || !hit);
            ST_FILL: begin
                mem_req   = 1'b1;
                fill_en   = mem_ready;
                fill_last = (beat_q == LAST);
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                upd_en  = mem_ready && hit;
            end
            ST_WDONE: cpu_stall = 1'b0;
        endcase
    end

    assign beat = beat_q;

    // R8: a pending memory request keeps its beat and direction
    a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(beat_q) && $stable(mem_we)));

    // R4: fill beats advance one by one in ascending order
    a_r4_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && mem_ready && beat_q != LAST)
            |=> (state_q == ST_FILL && beat_q == $past(beat_q) + 1'b1));

    // R5: the processor is released the cycle after the write handshake
    a_r5_write_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && mem_ready) |=> !cpu_stall);

endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache #(
    parameter int ADDR_W     = 24,
    parameter int LINE_BITS  = 8,
    parameter int LINE_BYTES = 4,
    parameter int WORD_BYTES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [8*WORD_BYTES-1:0] cpu_wdata,
    input  logic [WORD_BYTES-1:0]   cpu_be,
    output logic [8*WORD_BYTES-1:0] cpu_rdata,
    output logic                    cpu_stall,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [8*WORD_BYTES-1:0] mem_wdata,
    output logic [WORD_BYTES-1:0]   mem_be,
    input  logic [8*WORD_BYTES-1:0] mem_rdata,
    input  logic                    mem_ready
);
    localparam int DATA_W    = 8 * WORD_BYTES;
    localparam int LINES     = 1 << LINE_BITS;
    localparam int WPL       = LINE_BYTES / WORD_BYTES;
    localparam int OFF_BITS  = $clog2(LINE_BYTES);
    localparam int BYTE_BITS = $clog2(WORD_BYTES);
    localparam int WS_W      = OFF_BITS - BYTE_BITS;
    localparam int TAG_W     = ADDR_W - LINE_BITS - OFF_BITS;

    logic [TAG_W-1:0]     a_tag;
    logic [LINE_BITS-1:0] a_idx;
    logic [WS_W-1:0]      a_wsel;
    logic                 hit;
    logic [DATA_W-1:0]    rword;
    logic [WS_W-1:0]      beat;
    logic                 fill_en, fill_last, upd_en;

    // R1: field split
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign a_idx  = cpu_addr[OFF_BITS +: LINE_BITS];
    assign a_wsel = cpu_addr[BYTE_BITS +: WS_W];

    dmc_ctrl #(.WPL(WPL)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .hit       (hit),
        .mem_ready (mem_ready),
        .cpu_stall (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .beat      (beat),
        .fill_en   (fill_en),
        .fill_last (fill_last),
        .upd_en    (upd_en)
    );

    dmc_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .WPL    (WPL)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (a_idx),
        .tag       (a_tag),
        .wsel      (a_wsel),
        .hit       (hit),
        .rword     (rword),
        .fill_en   (fill_en),
        .fill_last (fill_last),
        .fill_beat (beat),
        .fill_word (mem_rdata),
        .upd_en    (upd_en),
        .upd_be    (cpu_be),
        .upd_word  (cpu_wdata)
    );

    assign cpu_rdata = rword;
    assign mem_addr  = mem_we ? cpu_addr : {a_tag, a_idx, beat, {BYTE_BITS{1'b0}}};
    assign mem_wdata = cpu_wdata;
    assign mem_be    = mem_we ? cpu_be : '1;

    // R3: an accepted read never involves memory
    a_r3_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_stall) |-> !mem_req);

endmodule

// File: tb/dm_wt_cache_bench.sv
module dm_wt_cache_bench;
    localparam int HALF = 10;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [1:0]  cpu_be = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_stall;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_be;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #HALF clk = ~clk;

    dm_wt_cache u_dm_wt_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] mem   [4096];
    logic [15:0] ref_m [4096];
    int          n_rd, n_wr, wcnt, lat, r8_bad;
    logic [23:0] rd_log [4];
    logic [23:0] wr_addr, hold_addr;
    logic [1:0]  wr_be;

    function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] d, logic [1:0] be);
        logic [15:0] r = old;
        if (be[0]) r[7:0]  = d[7:0];
        if (be[1]) r[15:8] = d[15:8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory model: acknowledges after 0..2 waiting cycles
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt > 0 && mem_addr != hold_addr) r8_bad++;
            hold_addr = mem_addr;
            if (wcnt >= lat) begin
                mem_ready = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[12:1]] = merge(mem[mem_addr[12:1]], mem_wdata, mem_be);
                    wr_addr = mem_addr;
                    wr_be = mem_be;
                    n_wr++;
                end else begin
                    mem_rdata = mem[mem_addr[12:1]];
                    if (n_rd < 4) rd_log[n_rd] = mem_addr;
                    n_rd++;
                end
                lat = (lat + 1) % 3;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic access(input bit we, input logic [23:0] a, input logic [15:0] d,
                          input logic [1:0] be, output logic [15:0] rd, output int stalls);
        @(negedge clk);
        n_rd = 0;
        n_wr = 0;
        cpu_req = 1'b1;
        cpu_we = we;
        cpu_addr = a;
        cpu_wdata = d;
        cpu_be = be;
        stalls = 0;
        #(HALF/2);
        while (cpu_stall && stalls < 64) begin
            stalls++;
            @(negedge clk);
            #(HALF/2);
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    // Run one access and check it against the reference model.
    task automatic run_op(input bit we, input logic [23:0] a, input logic [15:0] d,
                          input logic [1:0] be, input bit exp_hit, input string req);
        logic [15:0] rd;
        int st;
        access(we, a, d, be, rd, st);
        if (we) begin
            ref_m[a[12:1]] = merge(ref_m[a[12:1]], d, be);
            check(n_wr == 1 && wr_addr == a && wr_be == be, "R5", "write transfer",
                  {8'h0, wr_addr}, {8'h0, a});
            check(mem[a[12:1]] == ref_m[a[12:1]], "R5", "memory word after write",
                  {16'h0, mem[a[12:1]]}, {16'h0, ref_m[a[12:1]]});
            check(n_rd == 0 && st > 0, "R7", "write starts no fill",
                  n_rd, 0);
        end else begin
            check(rd == ref_m[a[12:1]], req, "read data", {16'h0, rd},
                  {16'h0, ref_m[a[12:1]]});
            if (exp_hit) begin
                check(st == 0 && n_rd == 0, req, "hit without stall (stalls)", st, 0);
            end else begin
                check(st > 0 && n_rd == 2, req, "miss fill beats", n_rd, 2);
                check(rd_log[0] == {a[23:2], 2'b00} && rd_log[1] == {a[23:2], 2'b10},
                      "R1", "fill beat addresses", {8'h0, rd_log[0]},
                      {8'h0, a[23:2], 2'b00});
            end
        end
    endtask

    typedef struct packed {
        logic        we;
        logic [23:0] addr;
        logic [15:0] wdata;
        logic [1:0]  be;
        logic        exp_hit;
    } vec_t;

    localparam int NV = 15;
    // A = 0x000404 (tag 1, line 1), B = 0x000C04 (tag 3, line 1), C = 0x000808 (line 2)
    localparam vec_t VECS [NV] = '{
        '{1'b0, 24'h000404, 16'h0000, 2'b00, 1'b0},  // R2 first read misses
        '{1'b0, 24'h000404, 16'h0000, 2'b00, 1'b1},  // R3 hit
        '{1'b0, 24'h000406, 16'h0000, 2'b00, 1'b1},  // R4 second word filled
        '{1'b0, 24'h000808, 16'h0000, 2'b00, 1'b0},  // R10 other line misses
        '{1'b0, 24'h000404, 16'h0000, 2'b00, 1'b1},  // R10 first line kept
        '{1'b1, 24'h000404, 16'h1234, 2'b01, 1'b1},  // R6 write hit low byte
        '{1'b0, 24'h000404, 16'h0000, 2'b00, 1'b1},  // R6 merged word
        '{1'b1, 24'h000C04, 16'hBEEF, 2'b11, 1'b0},  // R7 write miss
        '{1'b0, 24'h000C04, 16'h0000, 2'b00, 1'b0},  // R7 still misses
        '{1'b0, 24'h000404, 16'h0000, 2'b00, 1'b0},  // R9 thrash
        '{1'b0, 24'h000C04, 16'h0000, 2'b00, 1'b0},  // R9
        '{1'b0, 24'h000404, 16'h0000, 2'b00, 1'b0},  // R9
        '{1'b0, 24'h000C04, 16'h0000, 2'b00, 1'b0},  // R9
        '{1'b1, 24'h000C06, 16'hA55A, 2'b11, 1'b1},  // R6 write hit word 1
        '{1'b0, 24'h000C06, 16'h0000, 2'b00, 1'b1}   // R6 read back
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R10";
            5, 6, 13, 14: return "R6";
            7, 8: return "R7";
            default: return "R9";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i]   = 16'(i * 40503) ^ 16'h5A3C;
            ref_m[i] = mem[i];
        end
        n_rd = 0; n_wr = 0; wcnt = 0; lat = 0; r8_bad = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #(HALF/2);
        check(!cpu_stall && !mem_req, "R2", "idle after reset",
              {30'h0, cpu_stall, mem_req}, 0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be,
                   VECS[i].exp_hit, vec_req(i));
        end

        // R9: longer alternation between two blocks of line 1
        for (int k = 0; k < 6; k++) begin
            run_op(1'b0, (k % 2 == 0) ? 24'h000404 : 24'h000C04, 16'h0, 2'b00, 1'b0, "R9");
        end

        // R10 / R3: line 2 still resident, its second word hits
        run_op(1'b0, 24'h00080A, 16'h0, 2'b00, 1'b1, "R10");

        // R2: reset in mid-run clears the valid bits
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_op(1'b0, 24'h000808, 16'h0, 2'b00, 1'b0, "R2");
        run_op(1'b0, 24'h000808, 16'h0, 2'b00, 1'b1, "R3");

        check(r8_bad == 0, "R8", "request held stable while waiting", r8_bad, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(2 * HALF * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule